// File: doc/BRIEF.md
# Memory Bus Interface Unit

This unit connects a processor datapath to a memory bus that is 32 bits wide. The datapath makes a request with an address, a 3-bit transfer type that chooses both the size (byte, word of 16 bits, or long of 32 bits) and the extension mode, a read or write direction and write data. The unit turns this request into a single aligned access on the memory bus. It drives byte enables and places write data on the lanes that the access can occupy. It then waits for the memory acknowledge and returns the selected read bytes to the datapath, zero-extended or sign-extended to 32 bits.

Byte lanes are big-endian: the byte at address offset 0 sits in bits 31:24 of the memory word. A word access that is not at an even address, a long access that is not on a 4-byte boundary, and a reserved transfer type are all refused. In each of these cases the unit reports a one-cycle error and never touches the memory bus. All outputs come from registers.

Top module: `mem_bus_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_rd`, `mem_wr`, `rsp_done` and `rsp_error` are 0 and `mem_be` is 0.
- R2: A word request (`req_type[1:0]`=01) with `req_addr[0]`=1, or a long request (`req_type[1:0]`=10) with `req_addr[1:0]`≠00, raises `rsp_error` for exactly one cycle, in the cycle after the request is sampled. It never asserts `mem_rd` or `mem_wr`.
- R3: The reserved transfer types 011 and 111 are refused in the same way as in R2, for both reads and writes.
- R4: Byte reads (type 000 for zero extension, 100 for sign extension) return the byte in lane `req_addr[1:0]`, where offset 0 is `mem_rdata[31:24]` and offset 3 is `mem_rdata[7:0]`. With type 100, bit 7 of that byte fills bits 31:8 of the result.
- R5: Word reads return `mem_rdata[31:16]` for offset 0 and `mem_rdata[15:0]` for offset 2. Type 001 zero-extends the word and type 101 sign-extends it from bit 15.
- R6: Long reads (type 010 or 110) return `mem_rdata` unchanged.
- R7: `mem_be` (bit 3 is lane 31:24) is 1000 shifted right by the offset for a byte, 1100 or 0011 for a word at offset 0 or 2, and 1111 for a long. This applies to both reads and writes.
- R8: On a write, `mem_wdata` holds the low byte of `req_wdata` copied into all four lanes for a byte, the low half copied into both halves for a word, and the full value for a long.
- R9: `mem_addr` is `req_addr` with bits 1:0 cleared. The strobe stays high until the first cycle in which `mem_ack` is high. The strobe then falls and `rsp_done` is high for exactly the next cycle, with `rsp_rdata` valid in that cycle for reads.
- R10: `req_valid` is ignored while an access is waiting for `mem_ack`. It causes no second memory access and no extra response.
- R11: `mem_rd` and `mem_wr` are never high together. The first request after an error is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe from the datapath, sampled when the unit is idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address |
| req_type | input | 3 | Transfer type: bits 1:0 give the size, bit 2 selects sign extension |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_rdata | output | 32 | Extended read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | One-cycle bus error pulse |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 is lane 31:24 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Memory read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bound checker watches the bus protocol on every cycle. It checks that the strobes are exclusive, that the memory address is aligned, that the strobe is held until acknowledge, that each done follows an acknowledge as a single pulse, that an error never coincides with a strobe or a done, and that the enable pattern has a legal lane count. Only the bench scenarios can show the data path itself. These cover lane selection and sign or zero extension for every offset and type, the exact enable pattern and write replication for each size, the refusal of each misaligned and reserved case, and the fact that a request made while busy is dropped.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned OFF_W = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic             fault;
    logic [LANES-1:0] lanes;
    xfer_size_e       size;
    logic             sext;
    logic [OFF_W-1:0] off;
  } xfer_plan_t;
endpackage

// File: rtl/mbu_decode.sv
module mbu_decode
  import mbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        xtype,
  output xfer_plan_t        plan
);
  localparam logic [LANES-1:0] TOP_LANE  = {1'b1, {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] HI_HALF   = {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
  localparam logic [LANES-1:0] LO_HALF   = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

  always_comb begin
    plan.off  = addr[OFF_W-1:0];
    plan.size = xfer_size_e'(xtype[1:0]);
    plan.sext = xtype[2];
    case (plan.size)
      SZ_BYTE: begin
        plan.lanes = TOP_LANE >> plan.off;
        plan.fault = 1'b0;
      end
      SZ_WORD: begin
        plan.lanes = plan.off[OFF_W-1] ? LO_HALF : HI_HALF;
        plan.fault = plan.off[0];
      end
      SZ_LONG: begin
        plan.lanes = '1;
        plan.fault = |plan.off;
      end
      default: begin
        plan.lanes = '0;
        plan.fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mbu_wr_lanes.sv
module mbu_wr_lanes
  import mbu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  xfer_size_e        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    case (size)
      SZ_BYTE: dout = {LANES{din[7:0]}};
      SZ_WORD: dout = {2{din[HALF_W-1:0]}};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/mbu_rd_extract.sv
module mbu_rd_extract
  import mbu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  xfer_size_e        size,
  input  logic              sext,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [7:0]        lane_byte [LANES];
  logic [7:0]        pick_b;
  logic [HALF_W-1:0] pick_w;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_byte[i] = din[DATA_W-1-8*i -: 8];
  end

  assign pick_b = lane_byte[off];
  assign pick_w = off[OFF_W-1] ? din[HALF_W-1:0] : din[DATA_W-1:HALF_W];

  always_comb begin
    case (size)
      SZ_BYTE: dout = {{(DATA_W-8){sext & pick_b[7]}}, pick_b};
      SZ_WORD: dout = {{(DATA_W-HALF_W){sext & pick_w[HALF_W-1]}}, pick_w};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/mem_bus_unit.sv
module mem_bus_unit
  import mbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_type,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e            state;
  xfer_plan_t        req_plan;
  xfer_plan_t        held;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] ext_rdata;

  mbu_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (req_addr),
    .xtype (req_type),
    .plan  (req_plan)
  );

  mbu_wr_lanes #(.DATA_W(DATA_W)) u_wr (
    .size (req_plan.size),
    .din  (req_wdata),
    .dout (lane_wdata)
  );

  mbu_rd_extract #(.DATA_W(DATA_W)) u_rd (
    .size (held.size),
    .sext (held.sext),
    .off  (held.off),
    .din  (mem_rdata),
    .dout (ext_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held      <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_plan.fault) begin
              rsp_error <= 1'b1;
            end else begin
              mem_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
              mem_be    <= req_plan.lanes;
              mem_rd    <= ~req_write;
              mem_wr    <= req_write;
              mem_wdata <= req_write ? lane_wdata : '0;
              held      <= req_plan;
              state     <= ST_BUSY;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            if (mem_rd) rsp_rdata <= ext_rdata;
            mem_rd   <= 1'b0;
            mem_wr   <= 1'b0;
            mem_be   <= '0;
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mbu_checker.sv
module mbu_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              rsp_done,
  input logic              rsp_error
);
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r9_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

  a_r9_strobe_held: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ack) |=> (mem_rd || mem_wr));

  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(mem_ack && (mem_rd || mem_wr)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r2_error_no_strobe: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> !(mem_rd || mem_wr || rsp_done));

  a_r2_error_single: assert property (@(posedge clk) disable iff (rst)
    rsp_error |=> !rsp_error);

  a_r7_lane_count: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));
endmodule

bind mem_bus_unit mbu_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mem_bus_unit_test.sv
module mem_bus_unit_test;
  typedef struct {
    bit          err;
    bit          chk_data;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_type = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_done;
  logic        rsp_error;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_rd;
  logic        mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];

  bit          cur_err;
  bit          cur_wr;
  logic [31:0] cur_addr;
  logic [3:0]  cur_be;
  logic [31:0] cur_wdata;
  logic [31:0] cur_word;
  int          cur_delay;
  string       cur_tag;
  int          wait_cnt = 0;
  int          mem_hits = 0;

  always #2 clk = ~clk;

  mem_bus_unit uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic bit m_err(input logic [2:0] t, input logic [1:0] off);
    if (t[1:0] == 2'b11) return 1'b1;
    if (t[1:0] == 2'b01) return off[0];
    if (t[1:0] == 2'b10) return off != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [3:0] m_be(input logic [2:0] t, input logic [1:0] off);
    if (t[1:0] == 2'b00) return 4'b1000 >> off;
    if (t[1:0] == 2'b01) return (off == 2'b00) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] m_wdata(input logic [2:0] t, input logic [31:0] d);
    if (t[1:0] == 2'b00) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (t[1:0] == 2'b01) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] t, input logic [1:0] off, input logic [31:0] w);
    logic [31:0] sh;
    sh = w << (8 * off);
    if (t[1:0] == 2'b00) return t[2] ? 32'(signed'(sh[31:24])) : {24'd0, sh[31:24]};
    if (t[1:0] == 2'b01) return t[2] ? 32'(signed'(sh[31:16])) : {16'd0, sh[31:16]};
    return w;
  endfunction

  // Memory responder: checks the bus side and acknowledges
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (!rst && (mem_rd || mem_wr)) begin
      if (wait_cnt >= cur_delay) begin
        mem_hits++;
        check(!cur_err, {cur_tag, " no bus access on refused request"}, {30'd0, mem_rd, mem_wr}, 32'd0);
        check(mem_wr == cur_wr, {cur_tag, " R11 direction"}, {31'd0, mem_wr}, {31'd0, cur_wr});
        check(mem_addr == {cur_addr[31:2], 2'b00}, {cur_tag, " R9 address"}, mem_addr, {cur_addr[31:2], 2'b00});
        check(mem_be == cur_be, {cur_tag, " R7 byte enables"}, {28'd0, mem_be}, {28'd0, cur_be});
        if (cur_wr)
          check(mem_wdata == cur_wdata, {cur_tag, " R8 write lanes"}, mem_wdata, cur_wdata);
        mem_rdata = cur_word;
        mem_ack   = 1'b1;
        wait_cnt  = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // Monitor: pops expected responses
  always @(negedge clk) begin
    if (!rst && (rsp_done || rsp_error)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected response", {30'd0, rsp_done, rsp_error}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_error == e.err && rsp_done == !e.err, {e.tag, " response kind"},
              {30'd0, rsp_done, rsp_error}, {30'd0, !e.err, e.err});
        if (e.chk_data && rsp_done)
          check(rsp_rdata == e.data, {e.tag, " read data"}, rsp_rdata, e.data);
      end
    end
  end

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [2:0] t,
                      input logic [31:0] data, input int delay, input bit poke, input string tag);
    exp_t e;
    int hits0;
    cur_err   = m_err(t, addr[1:0]);
    cur_wr    = wr;
    cur_addr  = addr;
    cur_be    = m_be(t, addr[1:0]);
    cur_wdata = m_wdata(t, data);
    cur_word  = wr ? 32'hDEAD_BEEF : data;
    cur_delay = delay;
    cur_tag   = tag;
    hits0     = mem_hits;
    e.err      = cur_err;
    e.chk_data = !wr;
    e.data     = m_read(t, addr[1:0], data);
    e.tag      = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_type  = t;
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = addr ^ 32'h40;
      req_type  = 3'b000;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check((mem_hits - hits0) == (cur_err ? 0 : 1), {tag, " R10 access count"},
          mem_hits - hits0, cur_err ? 0 : 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr && !rsp_done && !rsp_error && mem_be == 0, "R1 in reset",
          {27'd0, mem_be, mem_rd, mem_wr, rsp_done, rsp_error}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_rd && !mem_wr && !rsp_done && !rsp_error && mem_be == 0, "R1 after reset",
          {27'd0, mem_be, mem_rd, mem_wr, rsp_done, rsp_error}, 32'd0);

    // R4 byte reads, every lane, both extensions
    for (int o = 0; o < 4; o++) begin
      xfer(0, 32'h100 + 32'(o), 3'b000, 32'h8A7F_C501, 1, 0, "R4 byte zero");
      xfer(0, 32'h100 + 32'(o), 3'b100, 32'h8A7F_C501, 0, 0, "R4 byte sign");
    end
    // R5 word reads
    xfer(0, 32'h200, 3'b001, 32'h8A7F_C501, 2, 0, "R5 word zero off0");
    xfer(0, 32'h200, 3'b101, 32'h8A7F_C501, 0, 0, "R5 word sign off0");
    xfer(0, 32'h202, 3'b101, 32'h8A7F_C501, 1, 0, "R5 word sign off2");
    xfer(0, 32'h202, 3'b101, 32'h1234_7ABC, 0, 0, "R5 word sign positive");
    xfer(0, 32'h202, 3'b001, 32'h1234_F0BC, 0, 0, "R5 word zero off2");
    // R6 long reads
    xfer(0, 32'h300, 3'b010, 32'hF00D_1234, 4, 0, "R6 long 010");
    xfer(0, 32'h304, 3'b110, 32'h8000_0001, 0, 0, "R6 long 110");
    // R7/R8 writes
    for (int o = 0; o < 4; o++)
      xfer(1, 32'h400 + 32'(o), 3'b000, 32'h1234_56A5, 0, 0, "R8 byte write");
    xfer(1, 32'h500, 3'b001, 32'hAAAA_BEEF, 1, 0, "R8 word write off0");
    xfer(1, 32'h502, 3'b101, 32'h5555_C0DE, 0, 0, "R8 word write off2");
    xfer(1, 32'h600, 3'b110, 32'h0123_4567, 2, 0, "R8 long write");
    // R2 misaligned, R3 reserved
    xfer(0, 32'h701, 3'b001, 32'h0, 0, 0, "R2 word off1");
    xfer(1, 32'h703, 3'b101, 32'h0, 0, 0, "R2 word write off3");
    xfer(0, 32'h702, 3'b010, 32'h0, 0, 0, "R2 long off2");
    xfer(1, 32'h701, 3'b110, 32'h0, 0, 0, "R2 long write off1");
    xfer(0, 32'h800, 3'b011, 32'h0, 0, 0, "R3 reserved 011");
    xfer(1, 32'h800, 3'b111, 32'h0, 0, 0, "R3 reserved 111");
    xfer(0, 32'h804, 3'b100, 32'h11_22_33_F4, 0, 0, "R11 after error");
    // R10 request while busy
    xfer(0, 32'h900, 3'b010, 32'hCAFE_0001, 4, 1, "R10 busy read");
    xfer(1, 32'h902, 3'b001, 32'h0000_7777, 3, 1, "R10 busy write");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule